// File: doc/BRIEF.md
# Indirect Access Window

This block lets a host on a 32-bit register bus reach a downstream bus through two steps. The host first loads an address register, then reads or writes one of three data windows. Each window stands for one kind of downstream cycle: configuration, I/O port or memory. Every data-window access becomes exactly one downstream request. That request carries the kind, the latched address with the byte offset merged into its low bits, the byte enables, the direction and the write data.

For configuration accesses the latched address is a packed token. The token holds the bus number in bits 23:16, the device/function in bits 15:8 and the register number in bits 7:0, with the two lowest bits zero. For I/O accesses it is the port number. The low two bits of the host's data-window address, together with the access size, pick the byte lanes. A host access is stalled, with `h_ready` low, until the downstream side acknowledges. Read data comes back with the lanes that were not accessed cleared to zero.

Top module: `ind_window`

## Requirements
- R1: After reset `h_ready` and `dn_valid` are 0 and the address register reads back as 0.
- R2: A host access whose address bits [11:2] equal those of 0x064 reaches the address register. A write stores all 32 bits of `h_wdata` whatever the size. A read returns the stored value. Either completes with `h_ready` high in the cycle after the request is taken, and no downstream request is made.
- R3: A host access to word 0x068, 0x06C or 0x070 (any low two bits) produces exactly one downstream request with `dn_kind` 0, 1 or 2 respectively. The request stays asserted with stable fields until `dn_ack`.
- R4: `dn_be` is 4'b0001 shifted left by addr[1:0] for size 0 (byte). For size 1 (halfword) it is 4'b0011 if addr[1] is 0 and 4'b1100 if addr[1] is 1; addr[0] is ignored. For size 2 or 3 (word) it is 4'b1111.
- R5: `dn_addr` is the address register's bits 31:2 followed by a lane offset. The lane offset is addr[1:0] for a byte, {addr[1],0} for a halfword and 00 for a word.
- R6: `dn_wr` equals `h_wr` and `dn_wdata` equals `h_wdata`, unchanged.
- R7: `h_ready` stays low while the request is pending. It rises for exactly one cycle, in the cycle after the `dn_ack` cycle. On a read, `h_rdata` is then `dn_rdata` with every byte lane outside `dn_be` cleared; on a write it is 0.
- R8: The address register keeps its value across any number of data-window accesses, so repeated accesses reuse it.
- R9: An access to any other word completes in the cycle after it is taken. It reads 0, makes no downstream request and leaves the address register unchanged on a write.
- R10: A configuration read issued after loading a token whose low byte is zero is an ordinary single request. Its address equals the token and it has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_req | input | 1 | Host access request, held until `h_ready` |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | 12 | Host byte offset |
| h_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| h_wdata | input | 32 | Host write data on its byte lanes |
| h_rdata | output | 32 | Host read data, valid with `h_ready` |
| h_ready | output | 1 | One-cycle completion pulse |
| dn_valid | output | 1 | Downstream request pending |
| dn_kind | output | 2 | 0 configuration, 1 I/O, 2 memory |
| dn_addr | output | 32 | Downstream address with lane offset |
| dn_be | output | 4 | Downstream byte enables |
| dn_wr | output | 1 | Downstream write |
| dn_wdata | output | 32 | Downstream write data |
| dn_ack | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data, valid with `dn_ack` |

## Verification
The assertions assume that the host holds `h_req` and its fields steady until `h_ready` and drops the request in that same cycle. They also assume that `dn_ack` only arrives while `dn_valid` is high. The bench drives every host access through one task that releases the request on the `h_ready` cycle. It raises the acknowledge for a single cycle only after it has seen the pending request, with delays of zero to two cycles.

// File: rtl/ind_window_pkg.sv
package ind_window_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int LANE_W = $clog2(BE_W);

    localparam logic [1:0] KIND_CFG = 2'd0;
    localparam logic [1:0] KIND_IO  = 2'd1;
    localparam logic [1:0] KIND_MEM = 2'd2;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_DONE} win_st_e;
    typedef enum logic [2:0] {SEL_ADDR, SEL_CFG, SEL_IO, SEL_MEM, SEL_NONE} win_sel_e;

    typedef struct packed {
        win_st_e             st;
        logic [DATA_W-1:0]   addr;
        logic [DATA_W-1:0]   rdata;
        logic                dvalid;
        logic [1:0]          kind;
        logic [DATA_W-1:0]   daddr;
        logic [BE_W-1:0]     be;
        logic                wr;
        logic [DATA_W-1:0]   wdata;
    } win_state_t;

    function automatic logic [DATA_W-1:0] be_to_mask(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction
endpackage

// File: rtl/ind_window_decode.sv
module ind_window_decode
    import ind_window_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] OFS_ADDR = 'h064,
    parameter logic [ADDR_W-1:0] OFS_CFG  = 'h068,
    parameter logic [ADDR_W-1:0] OFS_IO   = 'h06C,
    parameter logic [ADDR_W-1:0] OFS_MEM  = 'h070
) (
    input  logic [ADDR_W-1:0] ofs,
    output win_sel_e          sel
);
    localparam int WORD_HI = ADDR_W - 1;

    always_comb begin
        if (ofs[WORD_HI:2] == OFS_ADDR[WORD_HI:2])      sel = SEL_ADDR;
        else if (ofs[WORD_HI:2] == OFS_CFG[WORD_HI:2])  sel = SEL_CFG;
        else if (ofs[WORD_HI:2] == OFS_IO[WORD_HI:2])   sel = SEL_IO;
        else if (ofs[WORD_HI:2] == OFS_MEM[WORD_HI:2])  sel = SEL_MEM;
        else                                            sel = SEL_NONE;
    end
endmodule

// File: rtl/ind_window_lanes.sv
module ind_window_lanes
    import ind_window_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] low,
    output logic [BE_W-1:0]   be,
    output logic [LANE_W-1:0] lane
);
    localparam logic [BE_W-1:0] BYTE_BE = BE_W'(1);
    localparam logic [BE_W-1:0] HALF_BE = BE_W'(3);

    always_comb begin
        case (size)
            2'd0: begin
                lane = low;
                be   = BYTE_BE << low;
            end
            2'd1: begin
                lane = {low[LANE_W-1], 1'b0};
                be   = HALF_BE << {low[LANE_W-1], 1'b0};
            end
            default: begin
                lane = '0;
                be   = '1;
            end
        endcase
    end

    always_comb begin
        assert ($countones(be) == 1 || $countones(be) == 2 || be == '1)
            else $error("p_be_count_r4: bad byte-enable shape");
    end
endmodule

// File: rtl/ind_window.sv
module ind_window
    import ind_window_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_req,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [1:0]        h_size,
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    output logic              h_ready,
    output logic              dn_valid,
    output logic [1:0]        dn_kind,
    output logic [31:0]       dn_addr,
    output logic [3:0]        dn_be,
    output logic              dn_wr,
    output logic [31:0]       dn_wdata,
    input  logic              dn_ack,
    input  logic [31:0]       dn_rdata
);
    win_state_t        cur_q, nxt_d;
    win_sel_e          sel;
    logic [BE_W-1:0]   acc_be;
    logic [LANE_W-1:0] acc_lane;

    ind_window_decode #(.ADDR_W(ADDR_W)) u_decode (
        .ofs (h_addr),
        .sel (sel)
    );

    ind_window_lanes u_lanes (
        .size (h_size),
        .low  (h_addr[LANE_W-1:0]),
        .be   (acc_be),
        .lane (acc_lane)
    );

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            ST_IDLE: begin
                if (h_req) begin
                    case (sel)
                        SEL_ADDR: begin
                            if (h_wr) nxt_d.addr = h_wdata;
                            nxt_d.rdata = h_wr ? '0 : cur_q.addr;
                            nxt_d.st    = ST_DONE;
                        end
                        SEL_CFG, SEL_IO, SEL_MEM: begin
                            nxt_d.dvalid = 1'b1;
                            nxt_d.kind   = (sel == SEL_CFG) ? KIND_CFG :
                                           (sel == SEL_IO)  ? KIND_IO  : KIND_MEM;
                            nxt_d.daddr  = {cur_q.addr[DATA_W-1:LANE_W], acc_lane};
                            nxt_d.be     = acc_be;
                            nxt_d.wr     = h_wr;
                            nxt_d.wdata  = h_wdata;
                            nxt_d.st     = ST_WAIT;
                        end
                        default: begin
                            nxt_d.rdata = '0;
                            nxt_d.st    = ST_DONE;
                        end
                    endcase
                end
            end
            ST_WAIT: begin
                if (dn_ack) begin
                    nxt_d.dvalid = 1'b0;
                    nxt_d.rdata  = cur_q.wr ? '0 : (dn_rdata & be_to_mask(cur_q.be));
                    nxt_d.st     = ST_DONE;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_IDLE, default: '0};
        else        cur_q <= nxt_d;
    end

    assign h_ready  = (cur_q.st == ST_DONE);
    assign h_rdata  = cur_q.rdata;
    assign dn_valid = cur_q.dvalid;
    assign dn_kind  = cur_q.kind;
    assign dn_addr  = cur_q.daddr;
    assign dn_be    = cur_q.be;
    assign dn_wr    = cur_q.wr;
    assign dn_wdata = cur_q.wdata;

    // Pending request holds its fields until acknowledged (R3)
    p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ack |=> dn_valid && $stable(dn_addr) && $stable(dn_be) && $stable(dn_kind));

    // Byte enables take only legal shapes (R4)
    p_be_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> ($countones(dn_be) == 1 || dn_be == 4'b0011 || dn_be == 4'b1100 || dn_be == 4'b1111));

    // Downstream address upper bits come from the address register (R5)
    p_addr_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> dn_addr[31:2] == cur_q.addr[31:2]);

    // Ready is a single-cycle pulse and never overlaps a pending request (R7)
    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready |=> !h_ready);
    p_no_ready_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> !h_ready);

    // Address register changes only through its own write (R8)
    p_addr_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_q.st == ST_IDLE && h_req && h_wr && sel == SEL_ADDR) |=> $stable(cur_q.addr));

    // Undefined offsets complete next cycle without a request (R9)
    p_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.st == ST_IDLE && h_req && sel == SEL_NONE |=> h_ready && !dn_valid && h_rdata == '0);
endmodule

// File: tb/test_ind_window.sv
module test_ind_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0, h_wr = 1'b0;
    logic [11:0] h_addr = '0;
    logic [1:0]  h_size = '0;
    logic [31:0] h_wdata = '0, h_rdata;
    logic        h_ready, dn_valid, dn_wr;
    logic [1:0]  dn_kind;
    logic [31:0] dn_addr, dn_wdata;
    logic [3:0]  dn_be;
    logic        dn_ack = 1'b0;
    logic [31:0] dn_rdata = '0;

    int total = 0, bad = 0, cycles = 0;
    logic [31:0] rd_pat;

    always #2.5 clk = ~clk;

    ind_window i_ind_window (
        .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr),
        .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready),
        .dn_valid(dn_valid), .dn_kind(dn_kind), .dn_addr(dn_addr), .dn_be(dn_be),
        .dn_wr(dn_wr), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // captured request fields
    int          nreq, lat;
    logic [31:0] rd, c_addr, c_wdata;
    logic [1:0]  c_kind;
    logic [3:0]  c_be;
    logic        c_wr;

    task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input int dly);
        bit prev = 0;
        int wcnt = 0;
        @(negedge clk);
        h_req = 1'b1; h_wr = wr; h_addr = a; h_size = sz; h_wdata = wd;
        nreq = 0; lat = 0; rd = 'x;
        forever begin
            @(negedge clk);
            lat++;
            dn_ack = 1'b0;
            if (h_ready) begin
                rd = h_rdata;
                h_req = 1'b0;
                break;
            end
            if (dn_valid) begin
                if (!prev) begin
                    nreq++;
                    c_addr = dn_addr; c_wdata = dn_wdata; c_kind = dn_kind;
                    c_be = dn_be; c_wr = dn_wr; wcnt = 0;
                end else wcnt++;
                if (wcnt >= dly) begin
                    dn_ack = 1'b1;
                    dn_rdata = rd_pat;
                end
            end
            prev = dn_valid;
            if (lat > 50) begin
                check(0, "access timeout", lat, 50);
                h_req = 1'b0;
                break;
            end
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'd0) return 4'b0001 << lo;
        if (sz == 2'd1) return lo[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [1:0] exp_lane(input logic [1:0] sz, input logic [1:0] lo);
        if (sz == 2'd0) return lo;
        if (sz == 2'd1) return {lo[1], 1'b0};
        return 2'b00;
    endfunction

    function automatic logic [31:0] exp_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    initial begin
        logic [31:0] tok;
        logic [11:0] undef_ofs [6];
        undef_ofs = '{12'h000, 12'h060, 12'h074, 12'h078, 12'h100, 12'hFFC};
        rd_pat = 32'hDEAD_BEEF;

        repeat (3) @(negedge clk);
        check(h_ready == 1'b0, "R1 ready at reset", {31'b0, h_ready}, 0);
        check(dn_valid == 1'b0, "R1 valid at reset", {31'b0, dn_valid}, 0);
        rst_n = 1'b1;
        access(0, 12'h064, 2'd2, 0, 0);
        check(rd == 32'h0, "R1 address register after reset", rd, 0);

        // R2: address register write and readback, size ignored for writes
        access(1, 12'h064, 2'd0, 32'h00AB_1234, 0);
        check(nreq == 0, "R2 no request on write", nreq, 0);
        check(lat == 1, "R2 write latency", lat, 1);
        access(0, 12'h066, 2'd2, 0, 0);
        check(rd == 32'h00AB_1234, "R2 readback", rd, 32'h00AB_1234);
        check(lat == 1 && nreq == 0, "R2 read latency/no request", lat, 1);

        // Sweep: kind x size x lane offset x direction
        for (int k = 0; k < 3; k++) begin
            for (int sz = 0; sz < 3; sz++) begin
                tok = (32'(k + 1) << 16) | (32'(sz * 8 + 3) << 8) | 32'h0000_00FC;
                access(1, 12'h064, 2'd2, tok, 0);
                for (int lo = 0; lo < 4; lo++) begin
                    for (int w = 0; w < 2; w++) begin
                        logic [3:0]  be_e;
                        logic [31:0] wd;
                        int          d;
                        be_e = exp_be(2'(sz), 2'(lo));
                        wd = 32'h1357_9BDF ^ (32'(k * 64 + sz * 16 + lo * 4 + w) * 32'h0101_0101);
                        rd_pat = ~wd;
                        d = (lo + w + k) % 3;
                        access(w[0], 12'h068 + 12'(k * 4 + lo), 2'(sz), wd, d);
                        check(nreq == 1, "R3 exactly one request", nreq, 1);
                        check(c_kind == 2'(k), "R3 request kind", {30'b0, c_kind}, k);
                        check(c_be == be_e, "R4 byte enables", {28'b0, c_be}, {28'b0, be_e});
                        check(c_addr == {tok[31:2], exp_lane(2'(sz), 2'(lo))}, "R5 request address",
                              c_addr, {tok[31:2], exp_lane(2'(sz), 2'(lo))});
                        check(c_wr == w[0], "R6 direction", {31'b0, c_wr}, w);
                        if (w == 1) check(c_wdata == wd, "R6 write data", c_wdata, wd);
                        check(lat == d + 2, "R7 completion latency", lat, d + 2);
                        check(rd == (w == 1 ? 32'h0 : (rd_pat & exp_mask(be_e))), "R7 read data",
                              rd, (w == 1 ? 32'h0 : (rd_pat & exp_mask(be_e))));
                    end
                end
                access(0, 12'h064, 2'd2, 0, 0);
                check(rd == tok, "R8 address register kept", rd, tok);
            end
        end

        // R9: undefined offsets
        access(1, 12'h064, 2'd2, 32'h0055_AA00, 0);
        foreach (undef_ofs[i]) begin
            access(1, undef_ofs[i], 2'd2, 32'hFFFF_FFFF, 0);
            check(nreq == 0 && lat == 1, "R9 write completes without request", nreq, 0);
            access(0, undef_ofs[i], 2'd2, 0, 0);
            check(rd == 32'h0, "R9 reads zero", rd, 0);
            check(nreq == 0 && lat == 1, "R9 read completes without request", lat, 1);
        end
        access(0, 12'h064, 2'd2, 0, 0);
        check(rd == 32'h0055_AA00, "R9 address register untouched", rd, 32'h0055_AA00);

        // R10: configuration read after a token with its low byte cleared
        access(1, 12'h064, 2'd2, 32'h0003_1800, 0);
        rd_pat = 32'hCAFE_F00D;
        access(0, 12'h068, 2'd2, 0, 1);
        check(nreq == 1, "R10 single request", nreq, 1);
        check(c_addr == 32'h0003_1800 && c_kind == 2'd0 && c_be == 4'hF && !c_wr,
              "R10 request fields", c_addr, 32'h0003_1800);
        check(rd == 32'hCAFE_F00D, "R10 read data", rd, 32'hCAFE_F00D);
        access(0, 12'h064, 2'd2, 0, 0);
        check(rd == 32'h0003_1800, "R10 token kept", rd, 32'h0003_1800);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule